// File: doc/BRIEF.md
# Standby Entry and Release Controller

This block sits beside a small microcontroller core and decides what happens when the core decodes a halt instruction. The halt carries a 4-bit operand. One bit picks the depth of sleep: STOP, which stops the oscillator, or HALT, which gates the CPU clock and leaves the timer running. The other three bits choose which wake sources may end the sleep. A shared status flag controls entry. A halt is skipped when the flag is already set, or when the chosen wake condition already holds. The flag is updated in a different way in each case, so software can tell what happened.

When sleep ends, the block gives the fetch unit a one-cycle wake-action code. The code says whether to continue at the instruction after the halt (a wake source fired) or to restart at address zero (a reset request). A status-test path lets software load or clear the flag. Software clears the flag just before a halt so that the halt really puts the core to sleep.

Top module: `stb_ctrl`

## Requirements
- R1: After `rst` is high at a clock edge, `standby`, `osc_stop`, `cpu_gate` and `status_flag` are 0 and `wake_act` is 00.
- R2: Operand bit 3 set to 1 selects STOP. While asleep in STOP, `osc_stop`=1 and `cpu_gate`=0. Bit 3 set to 0 selects HALT, which gives `cpu_gate`=1 and `osc_stop`=0.
- R3: A `halt_stb` while awake, with `status_flag`=0 and the selected release condition false, sets `standby` to 1 in the next cycle.
- R4: A `halt_stb` while awake with `status_flag`=1 does not enter standby. In the next cycle the flag equals the selected release condition: 0 if false, 1 if true.
- R5: A `halt_stb` while awake with `status_flag`=0 and the release condition already true does not enter standby, and the flag becomes 1.
- R6: Operand bits 2:0 enable the wake sources: bit 0 enables `wake_src[0]` (key), bit 1 enables `wake_src[1]` (timer), bit 2 enables `wake_src[2]` (spare). The release condition is the OR of the enabled sources. A source whose bit is 0 does not end standby.
- R7: While asleep, a release condition seen at a clock edge clears `standby` in the next cycle. In that same cycle it sets `status_flag` to 1 and drives `wake_act`=01 (resume after the halt) for exactly one cycle.
- R8: In STOP mode the timer source `wake_src[1]` is ignored, even when operand bit 1 enables it.
- R9: `rst_req` always ends standby. It clears `status_flag` and drives `wake_act`=10 (restart at address 0) for one cycle, and it wins over a release condition in the same cycle.
- R10: A `halt_stb` while asleep is ignored: mode and standby are unchanged.
- R11: While awake and without a halt, `flag_wr` loads `flag_wdata` into `status_flag`. While asleep, `flag_wr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| halt_stb | input | 1 | One-cycle strobe: halt instruction executes |
| halt_op | input | 4 | Halt operand: bit 3 mode, bits 2:0 wake enables |
| wake_src | input | 3 | Wake sources: 0 key, 1 timer, 2 spare |
| rst_req | input | 1 | Reset request from reset pin or power-on clear |
| flag_wr | input | 1 | Status-test write strobe |
| flag_wdata | input | 1 | Value loaded into the status flag |
| standby | output | 1 | Core is in standby |
| osc_stop | output | 1 | Oscillator stop enable (STOP) |
| cpu_gate | output | 1 | CPU clock gate enable (HALT) |
| status_flag | output | 1 | Shared status flag |
| wake_act | output | 2 | 00 none, 01 resume next address, 10 restart at zero |

## Verification
A mode latched wrongly shows as the wrong one of `osc_stop`/`cpu_gate` in the first cycle of standby. A bad wake mask shows as the core staying asleep, or waking too early, one cycle after the source changes. A flag update taken from the wrong branch shows on `status_flag` one cycle after the halt, before any further instruction could mask it. A lost or stretched wake-action pulse shows as `wake_act` wrong in the cycle that standby drops, or in the cycle after it.

// File: rtl/stb_pkg.sv
package stb_pkg;
    localparam int N_SRC     = 3;
    localparam int OP_W      = N_SRC + 1;
    localparam int TIMER_IDX = 1;

    typedef enum logic {MODE_HALT = 1'b0, MODE_STOP = 1'b1} sleep_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'b00,
        ACT_RESUME  = 2'b01,
        ACT_RESTART = 2'b10
    } wake_act_e;

    typedef enum logic [1:0] {
        FL_HOLD, FL_SET, FL_CLR, FL_LOAD
    } flag_cmd_e;

    typedef struct packed {
        sleep_mode_e        mode;
        logic [N_SRC-1:0]   enables;
    } halt_cfg_t;

    function automatic halt_cfg_t unpack_op(input logic [OP_W-1:0] op);
        halt_cfg_t c;
        c.mode    = sleep_mode_e'(op[OP_W-1]);
        c.enables = op[N_SRC-1:0];
        return c;
    endfunction
endpackage

// File: rtl/stb_release.sv
module stb_release
    import stb_pkg::*;
(
    input  halt_cfg_t        cfg,
    input  logic [N_SRC-1:0] src,
    output logic             hit
);
    logic [N_SRC-1:0] live;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (i == TIMER_IDX) begin : g_timer
            assign live[i] = src[i] & cfg.enables[i] & (cfg.mode != MODE_STOP);
        end else begin : g_plain
            assign live[i] = src[i] & cfg.enables[i];
        end
    end

    assign hit = |live;
endmodule

// File: rtl/stb_flag.sv
module stb_flag
    import stb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_cmd_e cmd,
    input  logic      wdata,
    output logic      flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            unique case (cmd)
                FL_SET:  flag <= 1'b1;
                FL_CLR:  flag <= 1'b0;
                FL_LOAD: flag <= wdata;
                default: flag <= flag;
            endcase
        end
    end
endmodule

// File: rtl/stb_ctrl.sv
module stb_ctrl
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_stb,
    input  logic [OP_W-1:0]  halt_op,
    input  logic [N_SRC-1:0] wake_src,
    input  logic             rst_req,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic             standby,
    output logic             osc_stop,
    output logic             cpu_gate,
    output logic             status_flag,
    output logic [1:0]       wake_act
);
    halt_cfg_t  new_cfg, held_cfg;
    logic       new_hit, held_hit;
    flag_cmd_e  fcmd;
    logic       fdata;
    logic       enter;
    wake_act_e  act_q, act_d;

    assign new_cfg = unpack_op(halt_op);

    stb_release u_new  (.cfg(new_cfg),  .src(wake_src), .hit(new_hit));
    stb_release u_held (.cfg(held_cfg), .src(wake_src), .hit(held_hit));

    always_comb begin
        fcmd  = FL_HOLD;
        fdata = flag_wdata;
        enter = 1'b0;
        act_d = ACT_NONE;
        if (rst_req) begin
            fcmd  = FL_CLR;
            act_d = ACT_RESTART;
        end else if (standby) begin
            if (held_hit) begin
                fcmd  = FL_SET;
                act_d = ACT_RESUME;
            end
        end else if (halt_stb) begin
            if (status_flag) begin
                fcmd  = FL_LOAD;
                fdata = new_hit;
            end else if (new_hit) begin
                fcmd  = FL_SET;
            end else begin
                enter = 1'b1;
            end
        end else if (flag_wr) begin
            fcmd = FL_LOAD;
        end
    end

    stb_flag u_flag (.clk(clk), .rst(rst), .cmd(fcmd), .wdata(fdata), .flag(status_flag));

    always_ff @(posedge clk) begin
        if (rst) begin
            standby  <= 1'b0;
            held_cfg <= '0;
            act_q    <= ACT_NONE;
        end else begin
            act_q <= act_d;
            if (rst_req || (standby && held_hit)) begin
                standby <= 1'b0;
            end else if (enter) begin
                standby  <= 1'b1;
                held_cfg <= new_cfg;
            end
        end
    end

    assign osc_stop = standby & (held_cfg.mode == MODE_STOP);
    assign cpu_gate = standby & (held_cfg.mode == MODE_HALT);
    assign wake_act = act_q;

    // R3
    entry_needs_clear_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> !$past(status_flag));
    // R10
    halt_ignored_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (standby && halt_stb && !rst_req && !held_hit) |=> (standby && $stable(osc_stop)));
    // R7
    resume_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_act == ACT_RESUME) |-> (status_flag && !standby));
    // R9
    restart_awake_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_act == ACT_RESTART) |-> (!standby && !status_flag));
    // R2
    gate_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        standby |-> $onehot({osc_stop, cpu_gate}));
    // R7
    act_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_act != ACT_NONE) |=> (wake_act == ACT_NONE || $past(rst_req)));
endmodule

// File: tb/sim_stb_ctrl.sv
module sim_stb_ctrl;
    logic clk = 1'b0, rst = 1'b1;
    logic halt_stb = 0, rst_req = 0, flag_wr = 0, flag_wdata = 0;
    logic [3:0] halt_op = 0;
    logic [2:0] wake_src = 0;
    logic standby, osc_stop, cpu_gate, status_flag;
    logic [1:0] wake_act;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    stb_ctrl u0 (.clk(clk), .rst(rst), .halt_stb(halt_stb), .halt_op(halt_op),
        .wake_src(wake_src), .rst_req(rst_req), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .standby(standby), .osc_stop(osc_stop),
        .cpu_gate(cpu_gate), .status_flag(status_flag), .wake_act(wake_act));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic setflag(input logic v);
        flag_wr = 1; flag_wdata = v; cyc(); flag_wr = 0;
    endtask

    task automatic halt(input logic [3:0] op);
        halt_op = op; halt_stb = 1; cyc(); halt_stb = 0;
    endtask

    task automatic t_reset();
        rst = 1; cyc(); cyc(); rst = 0;
        chk("R1 standby", standby, 0); chk("R1 flag", status_flag, 0);
        chk("R1 act", wake_act, 0); chk("R1 gates", {osc_stop, cpu_gate}, 0);
    endtask

    task automatic t_halt_key_wake();
        setflag(0); halt(4'b0001);
        chk("R3 enter", standby, 1); chk("R2 halt gate", {osc_stop, cpu_gate}, 2'b01);
        cyc(); chk("R3 stays", standby, 1);
        wake_src = 3'b001; cyc(); wake_src = 0;
        chk("R7 wake", standby, 0); chk("R7 flag", status_flag, 1); chk("R7 act", wake_act, 1);
        cyc(); chk("R7 pulse", wake_act, 0);
    endtask

    task automatic t_stop_timer();
        setflag(0); halt(4'b1011);
        chk("R2 stop gate", {osc_stop, cpu_gate}, 2'b10);
        wake_src = 3'b010; cyc(); cyc();
        chk("R8 timer ignored", standby, 1);
        wake_src = 3'b011; cyc(); wake_src = 0;
        chk("R8 key wakes stop", standby, 0); chk("R7 act stop", wake_act, 1);
    endtask

    task automatic t_halt_timer();
        setflag(0); halt(4'b0010);
        wake_src = 3'b010; cyc(); wake_src = 0;
        chk("R6 timer wakes halt", standby, 0);
    endtask

    task automatic t_mask();
        setflag(0); halt(4'b0100);
        wake_src = 3'b011; cyc(); cyc();
        chk("R6 masked", standby, 1);
        wake_src = 3'b100; cyc(); wake_src = 0;
        chk("R6 spare wakes", standby, 0);
    endtask

    task automatic t_flag_set_halt();
        setflag(1); halt(4'b0001);
        chk("R4 no entry false", standby, 0); chk("R4 flag cleared", status_flag, 0);
        setflag(1); wake_src = 3'b001; halt(4'b0001); wake_src = 0;
        chk("R4 no entry true", standby, 0); chk("R4 flag kept", status_flag, 1);
    endtask

    task automatic t_already_true();
        setflag(0); wake_src = 3'b100; halt(4'b0100); wake_src = 0;
        chk("R5 no entry", standby, 0); chk("R5 flag set", status_flag, 1);
        chk("R5 no act", wake_act, 0);
    endtask

    task automatic t_rst_req();
        setflag(0); halt(4'b0001);
        rst_req = 1; wake_src = 3'b001; cyc(); rst_req = 0; wake_src = 0;
        chk("R9 leave", standby, 0); chk("R9 act", wake_act, 2);
        chk("R9 flag", status_flag, 0);
        cyc(); chk("R9 pulse", wake_act, 0);
    endtask

    task automatic t_halt_in_standby();
        setflag(0); halt(4'b0001);
        halt(4'b1000); cyc();
        chk("R10 still asleep", standby, 1);
        chk("R10 mode kept", {osc_stop, cpu_gate}, 2'b01);
        flag_wr = 1; flag_wdata = 1; cyc(); flag_wr = 0;
        chk("R11 write ignored asleep", status_flag, 0);
        wake_src = 3'b001; cyc(); wake_src = 0;
        chk("R10 wake on held mask", standby, 0);
    endtask

    task automatic t_flag_write();
        setflag(1); chk("R11 load 1", status_flag, 1);
        setflag(0); chk("R11 load 0", status_flag, 0);
    endtask

    initial begin
        cyc();
        t_reset();
        t_halt_key_wake();
        t_stop_timer();
        t_halt_timer();
        t_mask();
        t_flag_set_halt();
        t_already_true();
        t_rst_req();
        t_halt_in_standby();
        t_flag_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule